// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that runs one MDIO frame at a time toward external PHY devices. A host programs it through a small 32-bit register port with four word-aligned slots. The slots hold a setup word, a target word (PHY and register numbers), a 16-bit data word, and a command word. Writing the command word launches the frame. The block divides the system clock down to MDC, shifts the frame out on the MDIO line, and for read frames releases the line and captures the reply. A busy flag in the command word stays set until the frame is over.

The block handles two frame styles. The start pattern comes from the setup word: pattern 01 gives a direct-register frame and pattern 00 gives an indirect frame. The two-bit command code is sent on the wire as the opcode. In direct frames, code 1 writes and code 2 reads. In indirect frames, code 0 sends an address, 1 writes, 2 reads and then steps the register number, and 3 reads. The setup word also controls three other things: whether a 32-bit preamble is sent, whether the sampled input is used at all, and whether the sampled input is inverted.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads zero and MDC, the MDIO output and the MDIO output enable are all low. The register slot is chosen by reg_addr_i[3:2]: 0 is setup, 1 is target, 2 is data, 3 is command.
- R2: A command write while idle latches the code from bits 1:0 and the step flag from bit 2, and sets busy (command bit 31) from the next cycle on. A command write while busy changes neither the frame nor the command register.
- R3: MDC is low when idle. While busy, each bit time is D+1 clocks low followed by D+1 clocks high, where D is setup bits 12:5.
- R4: The frame is sent MSB first in this order: 32 ones when setup bit 2 is set (no preamble otherwise), the start code from setup bits 4:3, the command code, the PHY number (target bits 9:5), the register number (target bits 4:0), two turnaround bits, and 16 data bits.
- R5: A frame whose code has bit 1 clear drives MDIO for the whole frame, with turnaround 1 then 0 and the data register as payload. The output enable is low whenever the block is idle.
- R6: A frame whose code has bit 1 set releases MDIO from the first turnaround bit to the end of the frame. It takes 16 samples, MSB first, each on a rising MDC edge.
- R7: Each sample equals mdio_i XOR setup bit 1 when setup bit 0 is set, and 0 when setup bit 0 is clear.
- R8: Busy clears exactly N*2*(D+1) clocks after the launching write, where N is 64 with a preamble and 32 without. A read frame's captured word appears in the data register in that same cycle.
- R9: The register number (target bits 4:0) advances by one, wrapping at 31, when a frame finishes only if the start code was 00, the code was 2 and the step flag was set. In all other cases the target register is unchanged.
- R10: While busy, the MDIO output changes only when MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Byte offset of the register slot |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mdc_o | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
Some properties are checked by assertions on every cycle. These are: MDC held low and the line released while idle, a command write while busy leaving the command untouched, busy never dropping except at the end of a frame, and MDIO changing only at a falling MDC edge. The bench's scenarios are the only way to show the rest. That covers the exact bit order with and without preamble, the bit-time length at small and maximum dividers, and the captured word under inversion and under a disabled input. It also covers the register step, which is applied only for the indirect read-and-step code and wraps from 31 to 0.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_F_W = 5;
  localparam int PHY_F_W = 5;
  localparam int DAT_F_W = 16;
  localparam int HDR_W   = 2 + 2 + PHY_F_W + REG_F_W + 2;
  localparam int BODY_W  = HDR_W + DAT_F_W;

  typedef enum logic [1:0] {
    SEL_CFG = 2'd0,
    SEL_ADR = 2'd1,
    SEL_DAT = 2'd2,
    SEL_CMD = 2'd3
  } reg_sel_e;

  localparam logic [1:0] TA_DRIVE   = 2'b10;
  localparam logic [1:0] SOF_INDIR  = 2'b00;
  localparam logic [1:0] CODE_RDINC = 2'b10;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             mdc_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             half_q;
  logic             tick;

  assign tick = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      half_q <= ~half_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rise_o = run_i & tick & ~half_q;
  assign fall_o = run_i & tick & half_q;
  assign mdc_o  = half_q;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               pre_en_i,
  input  logic [1:0]         sof_i,
  input  logic [1:0]         code_i,
  input  logic [PHY_F_W-1:0] phy_i,
  input  logic [REG_F_W-1:0] reg_i,
  input  logic [DAT_F_W-1:0] wdata_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdi_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               rd_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic [DAT_F_W-1:0] rx_o
);
  localparam int TOT = PRE_BITS + BODY_W;
  localparam int CW  = $clog2(TOT);
  localparam logic [CW-1:0] REL_POS = CW'(DAT_F_W + 1);
  localparam logic [CW-1:0] SMP_POS = CW'(DAT_F_W);

  logic [TOT-1:0]     sreg_q;
  logic [CW-1:0]      rem_q;
  logic               busy_q, rd_q;
  logic [DAT_F_W-1:0] rx_q;
  logic [BODY_W-1:0]  body;

  assign body = {sof_i, code_i, phy_i, reg_i, TA_DRIVE, wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      rx_q   <= '0;
    end else if (start_i) begin
      sreg_q <= pre_en_i ? {{PRE_BITS{1'b1}}, body} : {body, {PRE_BITS{1'b0}}};
      rem_q  <= pre_en_i ? CW'(TOT - 1) : CW'(BODY_W - 1);
      busy_q <= 1'b1;
      rd_q   <= code_i[1];
    end else if (busy_q) begin
      if (rise_i && rd_q && rem_q < SMP_POS)
        rx_q <= {rx_q[DAT_F_W-2:0], mdi_i};
      if (fall_i) begin
        if (rem_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          sreg_q <= {sreg_q[TOT-2:0], 1'b0};
          rem_q  <= rem_q - 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q & fall_i & (rem_q == '0);
  assign rd_o      = rd_q;
  assign mdio_o    = busy_q & sreg_q[TOT-1];
  assign mdio_oe_o = busy_q & ~(rd_q & (rem_q <= REL_POS));
  // the final sample lands on the last rising edge, before done
  assign rx_o      = rx_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int DIV_W    = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  localparam int CFG_W = 5 + DIV_W;
  localparam int ADR_W = PHY_F_W + REG_F_W;

  logic [CFG_W-1:0]   cfg_q;
  logic [ADR_W-1:0]   adr_q;
  logic [DAT_F_W-1:0] dat_q;
  logic [1:0]         code_q;
  logic               step_q;

  reg_sel_e           sel;
  logic               start, busy, done, rd_frm, rise, fall, mdi;
  logic [DAT_F_W-1:0] rx;
  logic               post_inc;

  logic               mdi_en, mdi_inv, pre_en;
  logic [1:0]         sof;
  logic [DIV_W-1:0]   div;

  assign mdi_en  = cfg_q[0];
  assign mdi_inv = cfg_q[1];
  assign pre_en  = cfg_q[2];
  assign sof     = cfg_q[4:3];
  assign div     = cfg_q[5 +: DIV_W];

  assign sel      = reg_sel_e'(reg_addr_i[3:2]);
  assign start    = reg_we_i && (sel == SEL_CMD) && !busy;
  assign mdi      = mdi_en & (mdio_i ^ mdi_inv);
  assign post_inc = (sof == SOF_INDIR) && (code_q == CODE_RDINC) && step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      adr_q  <= '0;
      dat_q  <= '0;
      code_q <= '0;
      step_q <= 1'b0;
    end else begin
      if (reg_we_i && sel == SEL_CFG) cfg_q <= reg_wdata_i[CFG_W-1:0];
      if (reg_we_i && sel == SEL_ADR) adr_q <= reg_wdata_i[ADR_W-1:0];
      if (reg_we_i && sel == SEL_DAT) dat_q <= reg_wdata_i[DAT_F_W-1:0];
      if (start) begin
        code_q <= reg_wdata_i[1:0];
        step_q <= reg_wdata_i[2];
      end
      // frame completion wins over a host write in the same cycle
      if (done) begin
        if (rd_frm)   dat_q <= rx;
        if (post_inc) adr_q[REG_F_W-1:0] <= adr_q[REG_F_W-1:0] + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CFG: reg_rdata_o = {{(32-CFG_W){1'b0}}, cfg_q};
      SEL_ADR: reg_rdata_o = {{(32-ADR_W){1'b0}}, adr_q};
      SEL_DAT: reg_rdata_o = {{(32-DAT_F_W){1'b0}}, dat_q};
      default: reg_rdata_o = {busy, 28'd0, step_q, code_q};
    endcase
  end

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (div),
    .rise_o (rise),
    .fall_o (fall),
    .mdc_o  (mdc_o)
  );

  mdio_frame_eng #(.PRE_BITS(PRE_BITS)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .pre_en_i  (pre_en),
    .sof_i     (sof),
    .code_i    (reg_wdata_i[1:0]),
    .phy_i     (adr_q[REG_F_W +: PHY_F_W]),
    .reg_i     (adr_q[REG_F_W-1:0]),
    .wdata_i   (dat_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdi_i     (mdi),
    .busy_o    (busy),
    .done_o    (done),
    .rd_o      (rd_frm),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rx_o      (rx)
  );

  logic unused_bits;
  assign unused_bits = ^{reg_addr_i[1:0], reg_wdata_i[31:16]};
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [3:0] reg_addr_i,
  input logic       busy,
  input logic       done,
  input logic [1:0] code_q,
  input logic       mdc_o,
  input logic       mdio_o,
  input logic       mdio_oe_o
);
  // R2
  start_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i[3:2] == 2'd3 && !busy) |=> busy);

  // R2
  busy_cmd_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i[3:2] == 2'd3 && busy) |=> $stable(code_q));

  // R3
  idle_mdc_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);

  // R5
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdio_oe_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> busy);

  // R10
  mdio_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && !$fell(mdc_o)) |-> $stable(mdio_o));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .busy       (busy),
  .done       (done),
  .code_q     (code_q),
  .mdc_o      (mdc_o),
  .mdio_o     (mdio_o),
  .mdio_oe_o  (mdio_oe_o)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;

  mdio_master dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .mdc_o       (mdc),
    .mdio_i      (mdio_i),
    .mdio_o      (mdio_o),
    .mdio_oe_o   (mdio_oe)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R8 watchdog: act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] mk_cfg(input bit en, input bit inv, input bit pre,
                                         input logic [1:0] sof, input logic [7:0] dv);
    return {19'd0, dv, sof, pre, inv, en};
  endfunction

  task automatic run_frame(input string name, input logic [31:0] cfg, input logic [9:0] tgt,
                           input logic [15:0] dat, input logic [2:0] cmd,
                           input logic [15:0] resp, input bit collide);
    bit q[$];
    int p, n, tot, b, mm_clk, mm_out, mm_oe;
    bit hi, run, rdf, exp_oe;
    logic [15:0] exp_dat;
    logic [9:0]  exp_tgt;
    logic [31:0] v;
    p   = int'(cfg[12:5]) + 1;
    rdf = cmd[1];
    if (cfg[2]) for (int i = 0; i < 32; i++) q.push_back(1'b1);
    q.push_back(cfg[4]); q.push_back(cfg[3]);
    q.push_back(cmd[1]); q.push_back(cmd[0]);
    for (int i = 9; i >= 0; i--) q.push_back(tgt[i]);
    q.push_back(1'b1); q.push_back(1'b0);
    for (int i = 15; i >= 0; i--) q.push_back(dat[i]);
    n   = q.size();
    tot = n * 2 * p;
    mm_clk = 0; mm_out = 0; mm_oe = 0;
    wr(4'h0, cfg);
    wr(4'h4, {22'd0, tgt});
    wr(4'h8, {16'd0, dat});
    wr(4'hC, {29'd0, cmd});
    for (int k = 0; k <= tot; k++) begin
      b   = k / (2 * p);
      hi  = (k % (2 * p)) >= p;
      run = k < tot;
      if (collide && k == 4) we = 1'b0;
      if (run && rdf && b >= n - 16) mdio_i = resp[15 - (b - (n - 16))];
      else mdio_i = 1'b1;
      exp_oe = run && !(rdf && b >= n - 18);
      #1;
      if (rdata[31] !== run || mdc !== (run && hi)) mm_clk++;
      if (mdio_oe !== exp_oe) mm_oe++;
      if (exp_oe && mdio_o !== q[b]) mm_out++;
      if (collide && k == 3) begin
        wdata = {29'd0, ~cmd[2], ~cmd[1:0]};
        we = 1'b1;
      end
      @(negedge clk);
    end
    chk({"R3 R8 mdc/busy timing ", name}, mm_clk, 0);
    chk({"R4 R10 mdio bits ", name}, mm_out, 0);
    chk({rdf ? "R6" : "R5", " output enable ", name}, mm_oe, 0);
    if (rdf) exp_dat = cfg[0] ? (cfg[1] ? ~resp : resp) : 16'h0;
    else exp_dat = dat;
    rd(4'h8, v);
    chk({cfg[0] ? (cfg[1] ? "R7" : "R6") : "R7", " data reg ", name}, v, {16'd0, exp_dat});
    exp_tgt = tgt;
    if (cfg[4:3] == 2'b00 && cmd == 3'b110) exp_tgt[4:0] = tgt[4:0] + 5'd1;
    rd(4'h4, v);
    chk({"R9 target reg ", name}, v, {22'd0, exp_tgt});
    rd(4'hC, v);
    chk({"R2 command reg ", name}, v, {29'd0, cmd});
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(4'h0, v); chk("R1 reset setup", v, 0);
    rd(4'h4, v); chk("R1 reset target", v, 0);
    rd(4'h8, v); chk("R1 reset data", v, 0);
    rd(4'hC, v); chk("R1 reset command", v, 0);
    chk("R1 reset pins", {29'd0, mdc, mdio_o, mdio_oe}, 0);

    run_frame("dir write pre", mk_cfg(1,0,1,2'b01,8'd1), {5'h03,5'h11}, 16'hA5C3, 3'b001, 16'h0, 0);
    run_frame("dir read nopre", mk_cfg(1,0,0,2'b01,8'd0), {5'h1F,5'h02}, 16'h0, 3'b010, 16'h1234, 0);
    run_frame("read inverted", mk_cfg(1,1,0,2'b01,8'd2), {5'h05,5'h0A}, 16'h0, 3'b010, 16'hF00D, 0);
    run_frame("read mdi off", mk_cfg(0,0,1,2'b01,8'd1), {5'h01,5'h01}, 16'h7777, 3'b010, 16'hFFFF, 0);
    run_frame("ind address", mk_cfg(1,0,0,2'b00,8'd1), {5'h04,5'h03}, 16'h0042, 3'b000, 16'h0, 0);
    run_frame("ind rdinc wrap", mk_cfg(1,0,1,2'b00,8'd0), {5'h1A,5'h1F}, 16'h0, 3'b110, 16'h8001, 0);
    run_frame("ind rdinc nostep", mk_cfg(1,0,0,2'b00,8'd1), {5'h02,5'h07}, 16'h0, 3'b010, 16'h5A5A, 0);
    run_frame("ind read step", mk_cfg(1,0,0,2'b00,8'd0), {5'h02,5'h07}, 16'h0, 3'b111, 16'h00FF, 0);
    run_frame("dir read step", mk_cfg(1,0,0,2'b01,8'd0), {5'h02,5'h09}, 16'h0, 3'b110, 16'hC3C3, 0);
    run_frame("cmd while busy", mk_cfg(1,0,0,2'b01,8'd1), {5'h0C,5'h15}, 16'h3C3C, 3'b001, 16'h0, 1);
    run_frame("max divider", mk_cfg(1,0,0,2'b01,8'd255), {5'h11,5'h0E}, 16'hBEEF, 3'b001, 16'h0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule